// File: doc/BRIEF.md
# SONET Receive Channel Monitor

This block watches one received SONET channel after the line has already been bit- and byte-aligned. Bytes arrive one per clock with a marker on the first byte of each frame. The channel runs at either the 12-column-group or the 48-column-group rate. The block can strip the frame-synchronous scrambling from the payload. It checks the section parity byte of each frame against the parity of the frame before it, and it adds the bit errors it finds to a saturating counter. That counter is cleared when it is read.

Framing loss, signal loss and the measured skew against the local frame come in as status inputs from the framer and deskew logic, together with a provisioning bit. The block turns them into alarm outputs. A channel that has lost frame, lost signal or is not provisioned is treated as failed. A failed channel has its outgoing bytes replaced by an alarm-indication pattern or an unequipped pattern, and its lower-level alarms and parity counting are held off. An unprovisioned channel raises no alarm at all.

Top module: `rx_chan_monitor`

## Requirements
- R1: `sof_in` marks frame byte 0. A frame has ROWS x COLS x N bytes, where N = 48 when `sts48_mode` = 1 and N = 12 otherwise. `dout` and `sof_out` show the byte presented in a cycle on the next clock edge. Reset clears every output to 0.
- R2: When `dscr_en` = 1, every byte at frame position 3N or later, up to the end of the frame, is XORed with a key byte. The key comes from a 7-bit state that equals 7'h7F at position 3N. Each key bit, starting with the MSB, is state bit 6, after which the state shifts left by one and takes bit6 XOR bit5 into bit 0. Bytes before position 3N, and every byte when `dscr_en` = 0, pass unchanged.
- R3: The parity byte sits at frame position COLS x N. After descrambling it is compared with the even parity of each bit position over all bytes of the previous frame as received on the line, before descrambling. On a mismatch, `b1_err` pulses together with that byte on `dout`.
- R4: A parity check is made only when the previous frame was complete, meaning the next `sof_in` came exactly one frame length after its own, and the channel did not fail at any point from that frame's start until the check. The first frame after reset or after a failure is never checked.
- R5: `b1_cnt` adds the number of mismatched bits of each check and holds at 2^CNT_W-1 once it reaches that value.
- R6: With `cnt_rd` = 1, `b1_cnt` restarts from zero on the next edge. Any mismatch counted in the same cycle is kept, so the counter then equals that increment.
- R7: While `oof_in`, `los_in` or `!prov` holds, the byte on `dout` is replaced by 8'hFF if `ais_sel` = 1 and by 8'h00 if `ais_sel` = 0.
- R8: `oof_alm` and `los_alm` follow `oof_in` and `los_in` one cycle later when `prov` = 1. When `prov` = 0, all four alarm outputs stay 0.
- R9: `ooa_alm` is raised when the signed `skew` exceeds +24 or falls below -24 in 48 mode, or exceeds +12 or falls below -12 in 12 mode. It is held at 0 while the channel is failed.
- R10: While the channel is failed, no parity check is made and `b1_cnt` does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sts48_mode | input | 1 | 1: 48-group frame, 0: 12-group frame |
| dscr_en | input | 1 | Descrambling enable |
| prov | input | 1 | Channel provisioned |
| ais_sel | input | 1 | Substitution pattern: 1 all ones, 0 all zeros |
| oof_in | input | 1 | Framer reports out of frame |
| los_in | input | 1 | Loss of signal |
| skew | input | SKW_W | Signed skew in timeslots against the local frame |
| din | input | 8 | Received line byte |
| sof_in | input | 1 | First byte of frame |
| cnt_rd | input | 1 | Read strobe that clears the error counter |
| dout | output | 8 | Descrambled or substituted byte |
| sof_out | output | 1 | Frame start aligned with dout |
| oof_alm | output | 1 | Out-of-frame alarm |
| los_alm | output | 1 | Loss-of-signal alarm |
| ooa_alm | output | 1 | Out-of-alignment alarm |
| b1_err | output | 1 | Parity mismatch pulse |
| b1_cnt | output | CNT_W | Saturating parity bit-error count |

## Verification
The bench targets the points where a parity monitor usually slips. It sends a short frame followed by a frame with a corrupted parity byte; a design that checked without knowing the previous frame was complete would count those errors. It places a failure window over the parity byte and then over the frame before a check, so a design that ignored the failure history would count bogus errors. It reads the counter in the same cycle as a mismatch, which catches a design that clears the increment. It drives the counter into saturation, which catches one that wraps to a small value. It steps the skew across both tolerance limits in both directions, which exposes an off-by-one or an unsigned compare. It also compares every output byte against a keystream built from the stated generator, so a wrong restart point or bit order shows up at once.

// File: rtl/rx_chan_monitor.sv
module rx_chan_monitor #(
  parameter int COLS  = 90,
  parameter int ROWS  = 9,
  parameter int CNT_W = 16,
  parameter int SKW_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sts48_mode,
  input  logic                    dscr_en,
  input  logic                    prov,
  input  logic                    ais_sel,
  input  logic                    oof_in,
  input  logic                    los_in,
  input  logic signed [SKW_W-1:0] skew,
  input  logic [7:0]              din,
  input  logic                    sof_in,
  input  logic                    cnt_rd,
  output logic [7:0]              dout,
  output logic                    sof_out,
  output logic                    oof_alm,
  output logic                    los_alm,
  output logic                    ooa_alm,
  output logic                    b1_err,
  output logic [CNT_W-1:0]        b1_cnt
);

  localparam int F48 = ROWS * COLS * 48;
  localparam int F12 = ROWS * COLS * 12;
  localparam int PW  = $clog2(F48 + 1);
  localparam logic [PW-1:0] PMAX = '1;

  function automatic logic [14:0] scr_step(input logic [6:0] s);
    logic [7:0] k;
    logic [6:0] t;
    t = s;
    for (int i = 7; i >= 0; i--) begin
      k[i] = t[6];
      t    = {t[5:0], t[6] ^ t[5]};
    end
    return {k, t};
  endfunction

  logic [PW-1:0] pos_q, cur, flen, row_len, toh;
  logic [6:0]    lfsr_q, lfsr_nx;
  logic [7:0]    key, dsc, acc_q, par_q, mism;
  logic          pv_q, ok_q, failed, in_frm, scr_zone, chk, ooa;
  logic [3:0]    inc;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;
  logic signed [SKW_W:0] skx, lim;

  assign flen    = sts48_mode ? PW'(F48) : PW'(F12);
  assign row_len = sts48_mode ? PW'(COLS * 48) : PW'(COLS * 12);
  assign toh     = sts48_mode ? PW'(144) : PW'(36);

  assign cur      = sof_in ? '0 : ((pos_q == PMAX) ? PMAX : pos_q + 1'b1);
  assign in_frm   = cur < flen;
  assign scr_zone = in_frm && (cur >= toh);

  assign {key, lfsr_nx} = scr_step(lfsr_q);
  assign dsc    = din ^ ((dscr_en && scr_zone) ? key : 8'h00);
  assign failed = oof_in | los_in | ~prov;

  assign chk  = (cur == row_len) && pv_q && !failed;
  assign mism = chk ? (dsc ^ par_q) : 8'h00;
  assign inc  = 4'($countones(mism));
  assign base = cnt_rd ? '0 : b1_cnt;
  assign sum  = {1'b0, base} + (CNT_W+1)'(inc);

  assign skx = {skew[SKW_W-1], skew};
  assign lim = sts48_mode ? (SKW_W+1)'(24) : (SKW_W+1)'(12);
  assign ooa = (skx > lim) || (skx < -lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= PMAX;
      lfsr_q  <= '1;
      acc_q   <= '0;
      par_q   <= '0;
      pv_q    <= 1'b0;
      ok_q    <= 1'b0;
      dout    <= '0;
      sof_out <= 1'b0;
      oof_alm <= 1'b0;
      los_alm <= 1'b0;
      ooa_alm <= 1'b0;
      b1_err  <= 1'b0;
      b1_cnt  <= '0;
    end else begin
      pos_q <= cur;
      if (in_frm && cur == toh - 1'b1) lfsr_q <= '1;
      else if (scr_zone)               lfsr_q <= lfsr_nx;
      acc_q <= sof_in ? din : (acc_q ^ din);
      if (sof_in) par_q <= acc_q;
      if (failed)      pv_q <= 1'b0;
      else if (sof_in) pv_q <= ok_q && (pos_q == flen - 1'b1);
      ok_q    <= failed ? 1'b0 : (sof_in ? 1'b1 : ok_q);
      dout    <= failed ? {8{ais_sel}} : dsc;
      sof_out <= sof_in;
      oof_alm <= oof_in & prov;
      los_alm <= los_in & prov;
      ooa_alm <= ooa & ~failed;
      b1_err  <= |mism;
      b1_cnt  <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/rx_chan_monitor_chk.sv
module rx_chan_monitor_chk #(
  parameter int CNT_W = 16,
  parameter int SKW_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    prov,
  input logic                    ais_sel,
  input logic                    oof_in,
  input logic                    los_in,
  input logic signed [SKW_W-1:0] skew,
  input logic                    sof_in,
  input logic                    cnt_rd,
  input logic [7:0]              dout,
  input logic                    sof_out,
  input logic                    oof_alm,
  input logic                    los_alm,
  input logic                    ooa_alm,
  input logic                    b1_err,
  input logic [CNT_W-1:0]        b1_cnt
);

  a_r1_sof_follow: assert property (@(posedge clk) disable iff (!rst_n)
    sof_in |=> sof_out);

  a_r7_subst: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_in || los_in || !prov) |=> (dout == {8{$past(ais_sel)}}));

  a_r8_unprov_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !prov |=> !(oof_alm || los_alm || ooa_alm || b1_err));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rd |=> (b1_err ? (b1_cnt > $past(b1_cnt) || b1_cnt == '1)
                        : (b1_cnt == $past(b1_cnt))));

  a_r5_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (b1_cnt == '1 && !cnt_rd) |=> (b1_cnt == '1));

  a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd |=> (b1_cnt <= CNT_W'(8)));

  a_r10_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_in || los_in) |=> !(b1_err || ooa_alm));

  a_r9_in_tol: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(skew) <= 12 && $signed(skew) >= -12) |=> !ooa_alm);

endmodule

bind rx_chan_monitor rx_chan_monitor_chk #(.CNT_W(CNT_W), .SKW_W(SKW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prov(prov), .ais_sel(ais_sel), .oof_in(oof_in),
  .los_in(los_in), .skew(skew), .sof_in(sof_in), .cnt_rd(cnt_rd), .dout(dout),
  .sof_out(sof_out), .oof_alm(oof_alm), .los_alm(los_alm), .ooa_alm(ooa_alm),
  .b1_err(b1_err), .b1_cnt(b1_cnt)
);

// File: tb/rx_chan_monitor_bench.sv
module rx_chan_monitor_bench;
  localparam int CLK_P = 10;
  localparam int COLS  = 10;
  localparam int CNT_W = 6;
  localparam int SKW_W = 8;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int BIG   = 1 << 20;

  logic clk = 0, rst_n = 0;
  logic sts48_mode = 0, dscr_en = 1, prov = 1, ais_sel = 1, oof_in = 0, los_in = 0;
  logic signed [SKW_W-1:0] skew = 0;
  logic [7:0] din = 0;
  logic sof_in = 0, cnt_rd = 0;
  logic [7:0] dout;
  logic sof_out, oof_alm, los_alm, ooa_alm, b1_err;
  logic [CNT_W-1:0] b1_cnt;

  rx_chan_monitor #(.COLS(COLS), .ROWS(9), .CNT_W(CNT_W), .SKW_W(SKW_W)) u_rx_chan_monitor (
    .clk(clk), .rst_n(rst_n), .sts48_mode(sts48_mode), .dscr_en(dscr_en), .prov(prov),
    .ais_sel(ais_sel), .oof_in(oof_in), .los_in(los_in), .skew(skew), .din(din),
    .sof_in(sof_in), .cnt_rd(cnt_rd), .dout(dout), .sof_out(sof_out), .oof_alm(oof_alm),
    .los_alm(los_alm), .ooa_alm(ooa_alm), .b1_err(b1_err), .b1_cnt(b1_cnt));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  bit rskew = 1;

  int m_pos = BIG, m_cnt = 0;
  logic [6:0] m_lfsr = 7'h7F;
  logic [7:0] m_acc = 0, m_par = 0;
  bit m_pv = 0, m_ok = 0;
  logic [7:0] e_dout = 0;
  bit e_sof = 0, e_oof = 0, e_los = 0, e_ooa = 0, e_b1 = 0;
  int e_cnt = 0;
  string e_dtag = "R1 reset byte";

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] kstep(logic [6:0] s);
    logic [7:0] k;
    for (int i = 7; i >= 0; i--) begin
      k[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return {k, s};
  endfunction

  task automatic model_step(logic [7:0] d, bit s);
    int n = sts48_mode ? 48 : 12;
    int flen = 9 * COLS * n, rl = COLS * n, toh = 3 * n;
    int cur = s ? 0 : ((m_pos >= BIG) ? BIG : m_pos + 1);
    bit fail = oof_in | los_in | ~prov;
    bit zone = (cur < flen) && (cur >= toh);
    logic [14:0] ks = kstep(m_lfsr);
    logic [7:0] dsc = d ^ ((dscr_en && zone) ? ks[14:7] : 8'h00);
    logic [7:0] mism;
    int sk = int'(skew), lim = sts48_mode ? 24 : 12, b;
    e_dout = fail ? {8{ais_sel}} : dsc;
    e_dtag = fail ? "R7 substituted byte" : "R2 descrambled byte";
    e_sof = s; e_oof = oof_in & prov; e_los = los_in & prov;
    e_ooa = (sk > lim || sk < -lim) && !fail;
    mism = (cur == rl && m_pv && !fail) ? (dsc ^ m_par) : 8'h00;
    e_b1 = |mism;
    b = (cnt_rd ? 0 : m_cnt) + $countones(mism);
    m_cnt = (b > MAXC) ? MAXC : b;
    e_cnt = m_cnt;
    if (cur < flen && cur == toh - 1) m_lfsr = 7'h7F;
    else if (zone) m_lfsr = ks[6:0];
    if (s) m_par = m_acc;
    m_acc = s ? d : (m_acc ^ d);
    if (fail) m_pv = 0; else if (s) m_pv = m_ok && (m_pos == flen - 1);
    m_ok = fail ? 0 : (s ? 1 : m_ok);
    m_pos = cur;
  endtask

  task automatic cmp();
    chk(e_dtag, dout, e_dout);
    chk("R1 sof_out", sof_out, e_sof);
    chk("R8 oof_alm", oof_alm, e_oof);
    chk("R8 los_alm", los_alm, e_los);
    chk("R9 ooa_alm", ooa_alm, e_ooa);
    chk("R3 b1_err", b1_err, e_b1);
    chk("R5 b1_cnt", b1_cnt, e_cnt);
  endtask

  task automatic step(logic [7:0] d, bit s);
    din = d; sof_in = s;
    model_step(d, s);
    @(posedge clk);
    @(negedge clk);
    cmp();
  endtask

  function automatic logic [7:0] b1_line(logic [7:0] emask);
    logic [14:0] ks = kstep(m_lfsr);
    return m_par ^ (dscr_en ? ks[14:7] : 8'h00) ^ emask;
  endfunction

  task automatic send_frame(logic [7:0] emask, int len, int fkind, int f_lo, int f_hi, int rd_at);
    int n = sts48_mode ? 48 : 12;
    int flen = (len > 0) ? len : 9 * COLS * n;
    for (int p = 0; p < flen; p++) begin
      bit inw = (p >= f_lo && p <= f_hi);
      if (rskew && p % 64 == 0) skew = SKW_W'($urandom_range(80) - 40);
      oof_in = (fkind == 1) && inw;
      los_in = (fkind == 2) && inw;
      cnt_rd = (p == rd_at);
      if (p == COLS * n) step(b1_line(emask), 0);
      else step(8'($urandom), p == 0);
    end
    oof_in = 0; los_in = 0; cnt_rd = 0;
  endtask

  task automatic frm(logic [7:0] emask);
    send_frame(emask, 0, 0, -1, -1, -1);
  endtask

  task automatic skew_pt(int v, int exp, string tag);
    skew = SKW_W'(v);
    step(8'($urandom), 0);
    chk(tag, ooa_alm, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp();
    chk("R1 reset counter", b1_cnt, 0);

    frm(8'hFF);  chk("R4 first frame unchecked", b1_cnt, 0);
    frm(8'h00);  chk("R3 clean parity", b1_cnt, 0);
    frm(8'h01);  chk("R3 one bit error", b1_cnt, 1);
    frm(8'h81);  chk("R5 accumulate", b1_cnt, 3);
    send_frame(8'h00, 500, 0, -1, -1, -1);
    frm(8'hFF);  chk("R4 after short frame unchecked", b1_cnt, 3);
    frm(8'h0F);  chk("R3 four bit error", b1_cnt, 7);
    send_frame(8'h03, 0, 0, -1, -1, COLS * 12);
    chk("R6 read with same-cycle increment", b1_cnt, 2);
    send_frame(8'h00, 0, 0, -1, -1, 10);
    chk("R6 read clears", b1_cnt, 0);

    dscr_en = 0;
    frm(8'h00);  chk("R2 descramble off clean", b1_cnt, 0);
    frm(8'h10);  chk("R2 descramble off error", b1_cnt, 1);
    dscr_en = 1;
    frm(8'h00);  chk("R2 descramble on again", b1_cnt, 1);

    send_frame(8'hFF, 0, 1, 100, 140, -1);
    chk("R10 failed over parity byte", b1_cnt, 1);
    frm(8'hFF);  chk("R4 after failed frame unchecked", b1_cnt, 1);
    frm(8'h01);  chk("R3 recovered check", b1_cnt, 2);

    ais_sel = 0;
    send_frame(8'h01, 0, 2, 0, 50, -1);
    chk("R10 los early in frame", b1_cnt, 2);
    frm(8'h00);
    frm(8'h00);  chk("R3 clean after los", b1_cnt, 2);

    prov = 0;
    send_frame(8'hFF, 0, 1, 0, BIG, -1);
    chk("R8 unprovisioned oof alarm", oof_alm, 0);
    prov = 1; ais_sel = 1;
    frm(8'h00);
    frm(8'h00);  chk("R4 after unprovisioned", b1_cnt, 2);

    for (int i = 0; i < 9; i++) frm(8'hFF);
    chk("R5 saturated", b1_cnt, MAXC);
    send_frame(8'h00, 0, 0, -1, -1, 5);
    chk("R6 clear from max", b1_cnt, 0);

    sts48_mode = 1;
    frm(8'($urandom));
    frm(8'h3C);  chk("R3 48 mode error", b1_cnt, 4);
    frm(8'h00);  chk("R3 48 mode clean", b1_cnt, 4);

    rskew = 0;
    skew_pt(24, 0, "R9 48 at +24");
    skew_pt(25, 1, "R9 48 at +25");
    skew_pt(-25, 1, "R9 48 at -25");
    skew_pt(-24, 0, "R9 48 at -24");
    sts48_mode = 0;
    skew_pt(12, 0, "R9 12 at +12");
    skew_pt(13, 1, "R9 12 at +13");
    skew_pt(-13, 1, "R9 12 at -13");
    oof_in = 1;
    skew_pt(-40, 0, "R9 inhibited when failed");
    oof_in = 0;
    step(8'h00, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule